// File: doc/BRIEF.md
# Addressable Single-Bit Latch Bank with Three-State Bus

This block holds eight one-bit storage cells that are written one at a time from a single serial data line. A three-bit binary address picks the cell, and a write strobe copies the data bit into that cell. A master clear input empties the bank. When the clear and the strobe are raised together, the bank is cleared and the addressed cell is loaded in the same operation, so a single cycle leaves exactly one known bit in place.

All cell values are presented together on an eight-bit parallel bus. The bus has a three-state control, and that control acts on the output drivers only. The bus is modelled as a data vector that always follows the cells, together with a per-bit output-enable vector. A surrounding pad ring or bus fabric turns this pair into real three-state pins.

Everything is synchronous to one system clock. The strobe, clear, address and data inputs are sampled on the rising edge. The new cell contents appear on the bus just after the edge that sampled them. The output-enable vector follows the active-low enable input with no register in the path.

Top module: `addr_latch_bank`

## Requirements
- R1: `addr_i` selects cell number `addr_i` (binary, `addr_i[2]` most significant), and cell k is driven on `bus_o[k]`.
- R2: With `strobe_i` high, at a rising clock edge the selected cell takes the value of `din_i`, and it is visible on `bus_o` right after that edge.
- R3: With `strobe_i` high and `clear_i` low, every unselected cell keeps its value.
- R4: With `strobe_i` and `clear_i` both low, no cell changes at the clock edge, whatever `addr_i` and `din_i` are.
- R5: With `clear_i` high and `strobe_i` low, every cell is zero after the clock edge.
- R6: With `clear_i` and `strobe_i` both high, the selected cell loads `din_i` and every other cell becomes zero at the same edge.
- R7: `bus_oe_o` is all ones while `oe_n_i` is low and all zeros while `oe_n_i` is high, and it follows `oe_n_i` within the same cycle without waiting for a clock edge.
- R8: `bus_o` always equals the cell contents whatever the value of `oe_n_i`, and `oe_n_i` never changes a stored cell.
- R9: Holding `clear_i` high for one clock edge after power-up, with `strobe_i` low, puts all cells at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; inputs are sampled on its rising edge |
| strobe_i | input | 1 | Write strobe for the addressed cell |
| clear_i | input | 1 | Master clear of the bank, active high |
| addr_i | input | 3 | Binary cell address |
| din_i | input | 1 | Serial data bit |
| oe_n_i | input | 1 | Bus output enable, active low |
| bus_o | output | 8 | Cell contents, bit k = cell k |
| bus_oe_o | output | 8 | Per-bit driver enable for `bus_o` |

## Verification
The bench walks every address with both data values and checks that only the addressed bus bit moves. A decoder with swapped or stuck address bits would move a neighbouring bit, and a cell wired to the wrong write line would disturb bits that should be left alone. The combined clear-and-strobe case is tried for every address and both data values on a full bank. A design that gives the clear priority would lose the loaded bit, and one that gives the strobe priority would leave stale ones behind. The enable is toggled both between edges and across writes, to catch an output enable that waits for the clock and a bus that gates its data or its cells with the enable.

// File: rtl/latch_bank_pkg.sv
package latch_bank_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_CLEAR = 2'd1,
    CELL_LOAD  = 2'd2
  } cell_op_e;

  // A write to the cell wins over the bank clear; the clear wins over hold.
  function automatic cell_op_e cell_op(input logic wr, input logic clr);
    if (wr)       return CELL_LOAD;
    else if (clr) return CELL_CLEAR;
    else          return CELL_HOLD;
  endfunction

  function automatic logic cell_next(input cell_op_e op, input logic q, input logic d);
    case (op)
      CELL_LOAD:  return d;
      CELL_CLEAR: return 1'b0;
      default:    return q;
    endcase
  endfunction

endpackage

// File: rtl/lb_addr_decode.sv
module lb_addr_decode #(
  parameter int ADDR_W  = 3,
  parameter int N_CELLS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_CELLS-1:0] sel_o
);

  for (genvar k = 0; k < N_CELLS; k++) begin : g_sel
    assign sel_o[k] = (addr_i == ADDR_W'(k));
  end

  logic past_valid = 1'b0;
  always_ff @(posedge clk_i) past_valid <= 1'b1;

  // R1
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    $countones(sel_o) == 1);

endmodule

// File: rtl/lb_cell.sv
module lb_cell
  import latch_bank_pkg::*;
(
  input  logic clk_i,
  input  logic wr_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);

  cell_op_e op;
  logic     q_next;

  assign op     = cell_op(wr_i, clr_i);
  assign q_next = cell_next(op, q_o, d_i);

  always_ff @(posedge clk_i) q_o <= q_next;

  logic past_valid = 1'b0;
  always_ff @(posedge clk_i) past_valid <= 1'b1;

  // R2
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    wr_i |=> (q_o == $past(d_i)));

  // R4
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (!wr_i && !clr_i) |=> $stable(q_o));

  // R5
  clear_zeroes_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (clr_i && !wr_i) |=> !q_o);

endmodule

// File: rtl/lb_out_drive.sv
module lb_out_drive #(
  parameter int N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               oe_n_i,
  input  logic [N_CELLS-1:0] cells_i,
  output logic [N_CELLS-1:0] data_o,
  output logic [N_CELLS-1:0] oe_o
);

  assign data_o = cells_i;
  assign oe_o   = {N_CELLS{~oe_n_i}};

  logic past_valid = 1'b0;
  always_ff @(posedge clk_i) past_valid <= 1'b1;

  // R7
  oe_uniform_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (oe_o == '0) || (oe_o == '1));

  // R7
  oe_follows_pin_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (!oe_n_i) == oe_o[0]);

endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank #(
  parameter int ADDR_W = 3,
  localparam int N_CELLS = 1 << ADDR_W
) (
  input  logic               clk_i,
  input  logic               strobe_i,
  input  logic               clear_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               din_i,
  input  logic               oe_n_i,
  output logic [N_CELLS-1:0] bus_o,
  output logic [N_CELLS-1:0] bus_oe_o
);

  logic [N_CELLS-1:0] sel;
  logic [N_CELLS-1:0] wr;
  logic [N_CELLS-1:0] cells;

  lb_addr_decode #(.ADDR_W(ADDR_W), .N_CELLS(N_CELLS)) u_dec (
    .clk_i  (clk_i),
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    assign wr[k] = strobe_i & sel[k];
    lb_cell u_cell (
      .clk_i (clk_i),
      .wr_i  (wr[k]),
      .clr_i (clear_i),
      .d_i   (din_i),
      .q_o   (cells[k])
    );
  end

  lb_out_drive #(.N_CELLS(N_CELLS)) u_drv (
    .clk_i   (clk_i),
    .oe_n_i  (oe_n_i),
    .cells_i (cells),
    .data_o  (bus_o),
    .oe_o    (bus_oe_o)
  );

  logic past_valid = 1'b0;
  always_ff @(posedge clk_i) past_valid <= 1'b1;

  // R3
  unselected_keep_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (strobe_i && !clear_i) |=> ((bus_o & ~$past(sel)) == ($past(bus_o) & ~$past(sel))));

  // R6
  clear_load_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (strobe_i && clear_i) |=> (bus_o == ($past(sel) & {N_CELLS{$past(din_i)}})));

  // R8
  enable_no_store_chk: assert property (@(posedge clk_i) disable iff (!past_valid)
    (!strobe_i && !clear_i && $changed(oe_n_i)) |=> $stable(bus_o));

endmodule

// File: tb/tb_addr_latch_bank.sv
`timescale 1ns/1ps
module tb_addr_latch_bank;

  logic       clk = 1'b0;
  logic       strobe_i = 1'b0;
  logic       clear_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       din_i = 1'b0;
  logic       oe_n_i = 1'b0;
  logic [7:0] bus_o;
  logic [7:0] bus_oe_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_latch_bank dut (
    .clk_i    (clk),
    .strobe_i (strobe_i),
    .clear_i  (clear_i),
    .addr_i   (addr_i),
    .din_i    (din_i),
    .oe_n_i   (oe_n_i),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected bank contents after one edge, from the requirement rules.
  function automatic logic [7:0] apply(input logic [7:0] m, input logic s, input logic c,
                                       input logic [2:0] a, input logic d);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) begin
      if (s && int'(a) == k) r[k] = d;
      else if (c)            r[k] = 1'b0;
      else                   r[k] = m[k];
    end
    return r;
  endfunction

  // Called at a falling edge: drive, pass one rising edge, check at next falling edge.
  task automatic step(input logic s, input logic c, input logic [2:0] a, input logic d,
                      input logic oen, input string req);
    strobe_i = s; clear_i = c; addr_i = a; din_i = d; oe_n_i = oen;
    model = apply(model, s, c, a, d);
    @(negedge clk);
    check8(req, bus_o, model);
    check8("R7 oe", bus_oe_o, oen ? 8'h00 : 8'hFF);
  endtask

  task automatic fill(input logic [7:0] pat);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 3'(k), pat[k], 1'b0, "R2 fill");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R9: power-up clear
    step(1'b0, 1'b1, 3'd0, 1'b0, 1'b0, "R9 power-up clear");

    // R1 R2 R3: walk a one up, then zeros down
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 3'(k), 1'b1, 1'b0, "R1/R2/R3 set walk");
    for (int k = 7; k >= 0; k--) step(1'b1, 1'b0, 3'(k), 1'b0, 1'b0, "R1/R2/R3 clear walk");
    // R1: a single one at each address from an empty bank
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, 3'(k), 1'b1, 1'b0, "R1 single bit");
      check8("R1 position", bus_o, 8'h01 << k);
      step(1'b1, 1'b0, 3'(k), 1'b0, 1'b0, "R2 single clear");
    end

    // R4: idle with noisy address and data
    fill(8'hA5);
    for (int k = 0; k < 16; k++)
      step(1'b0, 1'b0, 3'(k), k[0], 1'b0, "R4 idle hold");
    check8("R4 pattern kept", bus_o, 8'hA5);

    // R5: clear alone
    step(1'b0, 1'b1, 3'd5, 1'b1, 1'b0, "R5 clear");
    check8("R5 zero", bus_o, 8'h00);

    // R6: clear with strobe, every address, both data values, full bank
    for (int k = 0; k < 8; k++) begin
      for (int d = 0; d < 2; d++) begin
        fill(8'hFF);
        step(1'b1, 1'b1, 3'(k), d[0], 1'b0, "R6 clear+load");
        check8("R6 result", bus_o, d[0] ? (8'h01 << k) : 8'h00);
      end
    end

    // R7 R8: enable toggled between edges, outputs follow at once
    fill(8'h3C);
    for (int k = 0; k < 6; k++) begin
      oe_n_i = ~oe_n_i;
      #0.5;
      check8("R7 async oe", bus_oe_o, oe_n_i ? 8'h00 : 8'hFF);
      check8("R8 data while oe moves", bus_o, 8'h3C);
      @(negedge clk);
      check8("R8 cells unchanged", bus_o, 8'h3C);
    end
    // R8: writes while disabled still reach bus_o
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, "R8 write disabled");
    step(1'b1, 1'b0, 3'd7, 1'b1, 1'b1, "R8 write disabled");
    check8("R8 bus data", bus_o, 8'hBD);

    // Mixed random traffic over all requirements
    for (int k = 0; k < 400; k++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[0], r[1] & r[2], r[5:3], 1'($urandom), 1'($urandom), "R2/R3/R4/R5/R6/R8 random");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule